// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block follows the fault state of a CAN node and governs how the node comes back after it has been forced off the bus. It watches the transmit error count from the error-counting logic. When that count passes its limit, the node moves to the bus-off state and its transmitter is switched off. While the node is off the bus, the block counts bus-idle sequences, each one a run of eleven back-to-back recessive bit times. It only counts bit times that are marked by a per-bit strobe from the bit-timing logic.

Once 128 idle sequences have been seen, the node can rejoin. A mode input selects how. When automatic rejoin is enabled, the node returns to normal operation by itself. When it is disabled, the node waits for a software request. A request made while the sequences are still being counted is remembered and acts as soon as the count is complete. Rejoining clears the sequence counter and sends a one-cycle pulse that resets the external transmit error count.

Top module: `busoff_recovery`

## Requirements
- R1: While active (state code 2'b00), a transmit error count above 255 (9-bit `tec`) moves the node to bus-off (code 2'b01) at the next clock edge. A count of exactly 255 does not. `tx_enable` is high only in the active state.
- R2: In bus-off, each clock with `bit_tick` high samples `bus_level`, where 1 is recessive and 0 is dominant. A dominant sample restarts the run of recessive samples. The 11th consecutive recessive sample adds one to `seq_count` and starts a new run. Clocks with `bit_tick` low change nothing.
- R3: `seq_count` stops at 128. `rejoin_ready` is high exactly when `seq_count` equals 128.
- R4: With `auto_rejoin` high, the node is active one clock after `seq_count` reaches 128.
- R5: With `auto_rejoin` low and no request seen, the node enters the rejoin-wait state (code 2'b10) one clock after `seq_count` reaches 128. It stays there until `sw_rejoin` or `auto_rejoin` is high, and then becomes active one clock later.
- R6: A `sw_rejoin` pulse given in bus-off before the count is complete is held. The node then becomes active one clock after `seq_count` reaches 128, even with `auto_rejoin` low. The node never becomes active before 128 sequences.
- R7: A `sw_rejoin` pulse given while the node is active is ignored. It does not shorten a later bus-off.
- R8: In the first active clock after a rejoin, `seq_count` is 0 and `tec_clear` is high. `tec_clear` is high for that single clock only.
- R9: After reset the node is active with `seq_count` 0, `tx_enable` high, and `rejoin_ready` and `tec_clear` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tec | input | 9 | Transmit error count |
| bit_tick | input | 1 | One-clock strobe, one per bit time |
| bus_level | input | 1 | Sampled bus level, 1 = recessive |
| sw_rejoin | input | 1 | Software request to leave bus-off |
| auto_rejoin | input | 1 | 1 = rejoin without software |
| node_state | output | 2 | 00 active, 01 bus-off, 10 waiting to rejoin |
| seq_count | output | 8 | Completed idle sequences |
| rejoin_ready | output | 1 | Recovery sequence complete |
| tx_enable | output | 1 | Node may drive the bus |
| tec_clear | output | 1 | One-clock pulse to reset the error count |

## Verification
Two events can land in the same clock. The first is the sequence count becoming complete; the second is a software request, either one that was latched earlier or a fresh one. The bench provokes this by raising `sw_rejoin` in the very clock in which `rejoin_ready` first reads high. It also issues requests at random points before completion. In every case it expects exactly one rejoin, one clock later, with a single `tec_clear` pulse, and never an early exit. A second overlap is a dominant bit arriving just as a run would reach eleven. This is covered by random dominant bits during recovery, which the bench scores against its own run and sequence tally.

// File: rtl/busoff_pkg.sv
package busoff_pkg;

  typedef enum logic [1:0] {
    NODE_ACTIVE = 2'b00,
    NODE_OFF    = 2'b01,
    NODE_WAIT   = 2'b10
  } node_state_t;

  // True when an error count is strictly above the bus-off limit.
  function automatic logic f_exceeds(input int unsigned val, input int unsigned lim);
    return val > lim;
  endfunction

  // True when a recessive sample closes a run of the given length.
  function automatic logic f_run_closes(input int unsigned run, input logic rec,
                                        input int unsigned len);
    return rec && (run == len - 1);
  endfunction

endpackage

// File: rtl/busoff_run_detect.sv
module busoff_run_detect #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_tick,
  input  logic bus_rec,
  output logic run_done
);
  import busoff_pkg::*;

  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_q;

  assign run_done = enable && bit_tick && f_run_closes(32'(run_q), bus_rec, RUN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!enable) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (!bus_rec || run_done) run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end
  end

  // R2: a dominant sample leaves no partial run behind
  a_r2_dominant_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bit_tick && !bus_rec) |=> (run_q == '0));

  // R2: run length never reaches the closing value as a stored count
  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < RUN_W'(RUN_LEN));

  // R2: clocks without a strobe leave the run untouched
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !bit_tick) |=> $stable(run_q));

endmodule

// File: rtl/busoff_seq_count.sv
module busoff_seq_count #(
  parameter int unsigned SEQ_NEEDED = 128,
  parameter int unsigned CNT_W      = $clog2(SEQ_NEEDED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  assign full = (cnt == CNT_W'(SEQ_NEEDED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (inc && !full)  cnt <= cnt + 1'b1;
  end

  // R3: the count never passes the required number of sequences
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SEQ_NEEDED));

  // R3: a completed count stays complete until cleared
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> full);

  // R8: a clear empties the counter
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/busoff_rejoin_fsm.sv
module busoff_rejoin_fsm
  import busoff_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tec_over,
  input  logic        seq_full,
  input  logic        sw_req,
  input  logic        auto_en,
  output node_state_t st,
  output logic        leave,
  output logic        counting_en,
  output logic        tec_clear
);

  logic pend_q;

  assign leave = ((st == NODE_OFF) && seq_full && (auto_en || pend_q || sw_req)) ||
                 ((st == NODE_WAIT) && (auto_en || sw_req));
  assign counting_en = (st == NODE_OFF) && !seq_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= NODE_ACTIVE;
      pend_q    <= 1'b0;
      tec_clear <= 1'b0;
    end else begin
      tec_clear <= leave;
      if (leave)                          pend_q <= 1'b0;
      else if (st == NODE_OFF && sw_req)  pend_q <= 1'b1;
      unique case (st)
        NODE_ACTIVE: if (tec_over && !tec_clear) st <= NODE_OFF;
        NODE_OFF:    if (leave)      st <= NODE_ACTIVE;
                     else if (seq_full) st <= NODE_WAIT;
        NODE_WAIT:   if (leave)      st <= NODE_ACTIVE;
        default:     st <= NODE_ACTIVE;
      endcase
    end
  end

  // R1: excess errors while active force bus-off
  a_r1_enter_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == NODE_ACTIVE && tec_over && !tec_clear) |=> (st == NODE_OFF));

  // R4: automatic mode rejoins once the sequences are complete
  a_r4_auto_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (st == NODE_OFF && seq_full && auto_en) |=> (st == NODE_ACTIVE));

  // R5: the wait state holds without a request
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == NODE_WAIT && !sw_req && !auto_en) |=> (st == NODE_WAIT));

  // R6: no rejoin before the sequence count is complete
  a_r6_no_early_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (st != NODE_ACTIVE && !seq_full) |=> (st != NODE_ACTIVE));

  // R8: the error-count reset is a single-clock pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tec_clear |=> !tec_clear);

endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery #(
  parameter int unsigned TEC_W        = 9,
  parameter int unsigned BUSOFF_LIMIT = 255,
  parameter int unsigned RUN_LEN      = 11,
  parameter int unsigned SEQ_NEEDED   = 128,
  localparam int unsigned CNT_W       = $clog2(SEQ_NEEDED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TEC_W-1:0] tec,
  input  logic             bit_tick,
  input  logic             bus_level,
  input  logic             sw_rejoin,
  input  logic             auto_rejoin,
  output logic [1:0]       node_state,
  output logic [CNT_W-1:0] seq_count,
  output logic             rejoin_ready,
  output logic             tx_enable,
  output logic             tec_clear
);
  import busoff_pkg::*;

  node_state_t st;
  logic tec_over, run_done, seq_full, leave, counting_en;

  assign tec_over = f_exceeds(32'(tec), BUSOFF_LIMIT);

  busoff_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (counting_en),
    .bit_tick (bit_tick),
    .bus_rec  (bus_level),
    .run_done (run_done)
  );

  busoff_seq_count #(.SEQ_NEEDED(SEQ_NEEDED), .CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (run_done),
    .clear (leave),
    .cnt   (seq_count),
    .full  (seq_full)
  );

  busoff_rejoin_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tec_over    (tec_over),
    .seq_full    (seq_full),
    .sw_req      (sw_rejoin),
    .auto_en     (auto_rejoin),
    .st          (st),
    .leave       (leave),
    .counting_en (counting_en),
    .tec_clear   (tec_clear)
  );

  assign node_state   = st;
  assign rejoin_ready = seq_full;
  assign tx_enable    = (st == NODE_ACTIVE);

  // R8: the clear pulse coincides with an empty sequence count
  a_r8_pulse_with_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tec_clear |-> (seq_count == '0 && tx_enable));

  // R1: the transmitter is silent whenever the sequence counter is running
  a_r1_silent_when_counting: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_count != '0) |-> !tx_enable);

endmodule

// File: tb/busoff_recovery_test.sv
module busoff_recovery_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tec = '0;
  logic       bit_tick = 1'b0, bus_level = 1'b1, sw_rejoin = 1'b0, auto_rejoin = 1'b0;
  logic [1:0] node_state;
  logic [7:0] seq_count;
  logic       rejoin_ready, tx_enable, tec_clear;

  int total = 0, bad = 0;
  int m_run = 0, m_seq = 0;
  bit done = 1'b0;

  localparam logic [1:0] S_ACT = 2'b00, S_OFF = 2'b01, S_WAIT = 2'b10;

  always #10 clk = ~clk;

  busoff_recovery uut (
    .clk(clk), .rst_n(rst_n), .tec(tec), .bit_tick(bit_tick), .bus_level(bus_level),
    .sw_rejoin(sw_rejoin), .auto_rejoin(auto_rejoin), .node_state(node_state),
    .seq_count(seq_count), .rejoin_ready(rejoin_ready), .tx_enable(tx_enable),
    .tec_clear(tec_clear)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench restatement of the run/sequence rule: returns the new sequence tally.
  function automatic int model_bit(inout int run, input int seq, input bit rec);
    if (!rec) begin run = 0; return seq; end
    run = run + 1;
    if (run == 11) begin run = 0; return (seq < 128) ? seq + 1 : seq; end
    return seq;
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic send(input bit tk, input bit lvl);
    bit_tick = tk; bus_level = lvl;
    cyc();
    bit_tick = 1'b0;
    if (tk) m_seq = model_bit(m_run, m_seq, lvl);
    chk("R2", "seq_count", seq_count, m_seq);
  endtask

  task automatic go_off();
    tec = 9'd300; cyc(); tec = 9'd0;
    chk("R1", "state", node_state, S_OFF);
    chk("R1", "tx_enable", tx_enable, 0);
    m_run = 0; m_seq = 0;
  endtask

  // Runs bits until the model says recovery is complete; optional early request.
  task automatic recover(input int dom_pct, input int req_at);
    int n = 0;
    while (m_seq < 128) begin
      if (n == req_at) begin sw_rejoin = 1'b1; end
      if ($urandom_range(9) == 0) send(1'b0, 1'($urandom_range(1)));
      else send(1'b1, ($urandom_range(99) >= dom_pct));
      sw_rejoin = 1'b0;
      if (m_seq < 128) chk("R6", "state before completion", node_state, S_OFF);
      n++;
    end
    chk("R3", "rejoin_ready", rejoin_ready, 1);
    chk("R3", "seq_count saturated", seq_count, 128);
  endtask

  task automatic check_rejoined();
    chk("R8", "state", node_state, S_ACT);
    chk("R8", "seq_count cleared", seq_count, 0);
    chk("R8", "tec_clear", tec_clear, 1);
    chk("R8", "tx_enable", tx_enable, 1);
    cyc();
    chk("R8", "tec_clear one clock", tec_clear, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R9 reset state
    chk("R9", "state", node_state, S_ACT);
    chk("R9", "seq_count", seq_count, 0);
    chk("R9", "tx_enable", tx_enable, 1);
    chk("R9", "rejoin_ready", rejoin_ready, 0);
    chk("R9", "tec_clear", tec_clear, 0);

    // R1 boundary: 255 keeps the node active
    tec = 9'd255; cyc(); cyc();
    chk("R1", "state at 255", node_state, S_ACT);
    tec = 9'd256; cyc(); tec = 9'd0;
    chk("R1", "state at 256", node_state, S_OFF);
    chk("R1", "tx_enable off", tx_enable, 0);
    m_run = 0; m_seq = 0;

    // R2 directed: 10 recessive then dominant gives nothing; unstrobed clocks ignored
    for (int i = 0; i < 10; i++) send(1'b1, 1'b1);
    send(1'b1, 1'b0);
    chk("R2", "after broken run", seq_count, 0);
    for (int i = 0; i < 11; i++) send(1'b1, 1'b1);
    chk("R2", "one full run", seq_count, 1);
    for (int i = 0; i < 20; i++) send(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) send(1'b1, 1'b1);
    chk("R2", "ten after idle clocks", seq_count, 1);
    send(1'b0, 1'b0);
    send(1'b1, 1'b1);
    chk("R2", "unstrobed dominant ignored", seq_count, 2);

    // R4 automatic rejoin
    auto_rejoin = 1'b1;
    recover(3, -1);
    chk("R4", "state at completion", node_state, S_OFF);
    cyc();
    chk("R4", "state after completion", node_state, S_ACT);
    check_rejoined();

    // R7 request while active is ignored; R5 wait state
    auto_rejoin = 1'b0;
    sw_rejoin = 1'b1; cyc(); sw_rejoin = 1'b0;
    chk("R7", "state after active request", node_state, S_ACT);
    go_off();
    recover(2, -1);
    cyc();
    chk("R7", "no stale request", node_state, S_WAIT);
    for (int i = 0; i < 30; i++) cyc();
    chk("R5", "wait holds", node_state, S_WAIT);
    chk("R5", "tx_enable in wait", tx_enable, 0);
    chk("R5", "ready in wait", rejoin_ready, 1);
    sw_rejoin = 1'b1; cyc(); sw_rejoin = 1'b0;
    chk("R5", "request leaves wait", node_state, S_ACT);
    check_rejoined();

    // R6 early request is held
    go_off();
    recover(2, 40);
    cyc();
    chk("R6", "pending request rejoins", node_state, S_ACT);
    check_rejoined();

    // R6 request in the completion clock itself
    go_off();
    recover(2, -1);
    sw_rejoin = 1'b1; cyc(); sw_rejoin = 1'b0;
    chk("R6", "same-clock request", node_state, S_ACT);
    check_rejoined();

    // R5 auto enable raised while waiting
    go_off();
    recover(2, -1);
    cyc();
    chk("R5", "wait entered", node_state, S_WAIT);
    auto_rejoin = 1'b1; cyc(); auto_rejoin = 1'b0;
    chk("R5", "auto leaves wait", node_state, S_ACT);
    check_rejoined();

    // Random rounds: mode and request timing drawn at random
    for (int r = 0; r < 4; r++) begin
      bit a = 1'($urandom_range(1));
      int at = ($urandom_range(1) == 1) ? int'($urandom_range(300)) : -1;
      auto_rejoin = a;
      go_off();
      recover(int'($urandom_range(4)), at);
      cyc();
      if (a || at >= 0) begin
        chk("R4", "random rejoin", node_state, S_ACT);
        check_rejoined();
      end else begin
        chk("R5", "random wait", node_state, S_WAIT);
        sw_rejoin = 1'b1; cyc(); sw_rejoin = 1'b0;
        check_rejoined();
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule